// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command pins of an SDRAM interface, as they are registered at each rising clock edge, and keeps a state machine for every bank. Each bank moves between idle, opening (row activation in progress), open, reading, writing, reading with auto-close, writing with auto-close and closing (precharge in progress). Cycle counters set by the activate-to-column delay (`T_RCD`), the precharge time (`T_RP`) and the burst length (`BURST_LEN`) carry each bank out of its timed states.

Every command that reaches a bank is checked against that bank's state. A command the state does not allow raises a violation pulse one cycle long. The pulse carries the bank number and the 3-bit command code. The illegal command is then dropped: no bank changes state because of it, but running timers keep counting. The block is a passive monitor for controller checking. It has no data path and no handshake. All pins are plain control and status signals.

`T_RCD`, `T_RP` and `BURST_LEN` must each be at least 2. `T_XSR` must be at least 1.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank reads idle (state code 0) on `bank_state` and `viol_valid` is low.
- R2: In idle (0), ACTIVE, AUTO REFRESH, LOAD MODE and PRECHARGE are legal. READ, WRITE and BURST STOP to an idle bank are violations.
- R3: An ACTIVE puts the bank in opening (1). The bank reads open (2) from `T_RCD` cycles after the ACTIVE. Any command other than NOP to an opening bank is a violation. Commands to the other bank are still checked only against that bank's own state.
- R4: In open (2), READ and WRITE with `a10` low enter reading (3) and writing (4). The bank returns to open `BURST_LEN` cycles after the command. ACTIVE, AUTO REFRESH and LOAD MODE to an open bank are violations.
- R5: While reading or writing, a new READ or WRITE restarts the burst count. BURST STOP returns the bank to open on the next cycle. PRECHARGE cuts the burst and enters closing.
- R6: PRECHARGE to an open or bursting bank enters closing (7). The bank reads idle from `T_RP` cycles after the PRECHARGE. Any command other than NOP to a closing bank is a violation.
- R7: READ or WRITE with `a10` high enters reading-auto-close (5) or writing-auto-close (6). The bank reads idle from `BURST_LEN + T_RP` cycles after the command. Commands to the bank before then are violations.
- R8: PRECHARGE with `a10` high, AUTO REFRESH and LOAD MODE address every bank. AUTO REFRESH and LOAD MODE are legal only when all banks are idle. A PRECHARGE to all banks leaves idle banks idle. When several banks reject a command, the lowest bank number is reported.
- R9: A violation appears on `viol_valid` for exactly the one cycle after the offending edge. `viol_bank` gives the bank and `viol_cmd` gives {ras_n,cas_n,we_n}: LOAD MODE=000, AUTO REFRESH=001, PRECHARGE=010, ACTIVE=011, WRITE=100, READ=101, BURST STOP=110. A rejected command changes no bank state.
- R10: Chip select high (inhibit) and NOP (111) never raise a violation and never disturb a bank or its timers.
- R11: A command is checked only when `cke` is high at both this edge and the previous edge. After `cke` rises, commands are ignored for `T_XSR` cycles. Ignored commands change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen by the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-close select on READ/WRITE, all-bank select on PRECHARGE |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_bank | output | BA_W | Bank that rejected the command |
| viol_cmd | output | 3 | Code of the rejected command |
| bank_state | output | 3*NUM_BANKS | State code of each bank, bank 0 in the low bits |

## Verification
Each state is probed with legal and illegal commands. Probing on the last blocked cycle and the first allowed cycle of every timed state separates a correct count from an off-by-one. Commands that address only one bank are mixed with all-bank commands, which shows whether a rejection stays confined to the bank that owns it and whether the lowest bank is chosen. Inhibit, NOP and `cke` sequences check that the timers keep running while ignored commands are dropped without any effect.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    BS_IDLE    = 3'd0,
    BS_OPENING = 3'd1,
    BS_OPEN    = 3'd2,
    BS_RD      = 3'd3,
    BS_WR      = 3'd4,
    BS_RD_AP   = 3'd5,
    BS_WR_AP   = 3'd6,
    BS_CLOSING = 3'd7
  } bank_st_e;

  // code is {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CM_LMR = 3'b000,
    CM_REF = 3'b001,
    CM_PRE = 3'b010,
    CM_ACT = 3'b011,
    CM_WR  = 3'b100,
    CM_RD  = 3'b101,
    CM_BST = 3'b110,
    CM_NOP = 3'b111
  } cmd_e;

  typedef struct packed {
    logic vld;
    cmd_e op;
    logic ap;
  } cmd_t;

endpackage

// File: rtl/sbt_cmd_gate.sv
module sbt_cmd_gate
  import sbt_pkg::*;
#(
  parameter int T_XSR = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_t cmd
);
  localparam int XW = (T_XSR > 1) ? $clog2(T_XSR) : 1;

  logic          cke_q;
  logic [XW-1:0] xsr_cnt;
  logic          chk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q   <= 1'b1;
      xsr_cnt <= '0;
    end else begin
      cke_q <= cke;
      if (cke && !cke_q)
        xsr_cnt <= XW'(T_XSR - 1);
      else if (xsr_cnt != '0)
        xsr_cnt <= xsr_cnt - 1'b1;
    end
  end

  always_comb begin
    chk_en  = cke && cke_q && (xsr_cnt == '0);
    cmd.op  = cmd_e'({ras_n, cas_n, we_n});
    cmd.ap  = a10;
    cmd.vld = chk_en && !cs_n && (cmd.op != CM_NOP);
  end

  // R11
  cke_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cke) |-> !chk_en);

endmodule

// File: rtl/sbt_bank_fsm.sv
module sbt_bank_fsm
  import sbt_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  parameter int BA_W      = 1,
  parameter int BANK_IDX  = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cmd_t            cmd,
  input  logic [BA_W-1:0] ba,
  input  logic            accept,
  output bank_st_e        state,
  output logic            illegal
);
  localparam int LD_ACT = T_RCD - 2;
  localparam int LD_PRE = T_RP - 2;
  localparam int LD_BUR = BURST_LEN - 2;
  localparam int LD_AP  = BURST_LEN + T_RP - 2;
  localparam int CW     = $clog2(LD_AP + LD_ACT + 2);

  logic [CW-1:0] cnt, ncnt;
  bank_st_e      nstate;
  logic          hit, all_bank, legal;

  always_comb begin
    all_bank = (cmd.op == CM_REF) || (cmd.op == CM_LMR) ||
               ((cmd.op == CM_PRE) && cmd.ap);
    hit = cmd.vld && (all_bank || (ba == BA_W'(BANK_IDX)));
    case (state)
      BS_IDLE:      legal = cmd.op inside {CM_ACT, CM_REF, CM_LMR, CM_PRE};
      BS_OPEN:      legal = cmd.op inside {CM_RD, CM_WR, CM_PRE};
      BS_RD, BS_WR: legal = cmd.op inside {CM_RD, CM_WR, CM_PRE, CM_BST};
      default:      legal = 1'b0;
    endcase
    illegal = hit && !legal;
  end

  always_comb begin
    nstate = state;
    ncnt   = cnt;
    if (cnt != '0) ncnt = cnt - 1'b1;
    else begin
      case (state)
        BS_OPENING, BS_RD, BS_WR:       nstate = BS_OPEN;
        BS_RD_AP, BS_WR_AP, BS_CLOSING: nstate = BS_IDLE;
        default: ;
      endcase
    end
    if (hit && accept) begin
      case (cmd.op)
        CM_ACT: begin
          nstate = BS_OPENING;
          ncnt   = CW'(LD_ACT);
        end
        CM_RD: begin
          nstate = cmd.ap ? BS_RD_AP : BS_RD;
          ncnt   = cmd.ap ? CW'(LD_AP) : CW'(LD_BUR);
        end
        CM_WR: begin
          nstate = cmd.ap ? BS_WR_AP : BS_WR;
          ncnt   = cmd.ap ? CW'(LD_AP) : CW'(LD_BUR);
        end
        CM_PRE: if (state != BS_IDLE) begin
          nstate = BS_CLOSING;
          ncnt   = CW'(LD_PRE);
        end
        CM_BST: begin
          nstate = BS_OPEN;
          ncnt   = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BS_IDLE;
      cnt   <= '0;
    end else begin
      state <= nstate;
      cnt   <= ncnt;
    end
  end

  // R3
  opening_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BS_OPENING) |=> (state inside {BS_OPENING, BS_OPEN}));

  // R6
  closing_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BS_CLOSING) |=> (state inside {BS_CLOSING, BS_IDLE}));

  // R7
  ap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {BS_RD_AP, BS_WR_AP}) |=> (state == $past(state) || state == BS_IDLE));

  // R9
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !accept && (state inside {BS_IDLE, BS_OPEN})) |=> (state == $past(state)));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  parameter  int T_RCD     = 3,
  parameter  int T_RP      = 3,
  parameter  int BURST_LEN = 4,
  parameter  int T_XSR     = 6,
  localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic                   a10,
  output logic                   viol_valid,
  output logic [BA_W-1:0]        viol_bank,
  output logic [2:0]             viol_cmd,
  output logic [3*NUM_BANKS-1:0] bank_state
);
  cmd_t                 cmd;
  logic [NUM_BANKS-1:0] ill;
  bank_st_e             st [NUM_BANKS];
  logic                 any_ill;
  logic [BA_W-1:0]      ill_idx;

  sbt_cmd_gate #(.T_XSR(T_XSR)) u_gate (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .cmd(cmd)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sbt_bank_fsm #(
      .T_RCD(T_RCD), .T_RP(T_RP), .BURST_LEN(BURST_LEN),
      .BA_W(BA_W), .BANK_IDX(g)
    ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .accept(!any_ill),
      .state(st[g]), .illegal(ill[g])
    );
    assign bank_state[3*g +: 3] = st[g];
  end

  // lowest rejecting bank wins
  always_comb begin
    any_ill = 1'b0;
    ill_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (ill[i]) begin
        any_ill = 1'b1;
        ill_idx = BA_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_bank  <= '0;
      viol_cmd   <= '0;
    end else begin
      viol_valid <= any_ill;
      viol_bank  <= ill_idx;
      viol_cmd   <= cmd.op;
    end
  end

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(!cs_n && cke));

endmodule

// File: tb/test_sdram_bank_tracker.sv
module test_sdram_bank_tracker;
  localparam int TRCD = 3, TRP = 3, BL = 4, TXSR = 6;
  localparam logic [2:0] OP_LMR = 3'b000, OP_REF = 3'b001, OP_PRE = 3'b010,
    OP_ACT = 3'b011, OP_WR = 3'b100, OP_RD = 3'b101, OP_BST = 3'b110, OP_NOP = 3'b111;

  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [0:0] ba = '0;
  logic viol_valid;
  logic [0:0] viol_bank;
  logic [2:0] viol_cmd;
  logic [5:0] bank_state;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sdram_bank_tracker #(.NUM_BANKS(2), .T_RCD(TRCD), .T_RP(TRP),
    .BURST_LEN(BL), .T_XSR(TXSR)) i_sdram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .viol_valid(viol_valid),
    .viol_bank(viol_bank), .viol_cmd(viol_cmd), .bank_state(bank_state));

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // drives a command, lets one edge register it, returns 2 ns after the edge
  task automatic issue(input logic [2:0] op, input logic b, input logic ap, input logic cs = 0);
    cs_n = cs; {ras_n, cas_n, we_n} = op; ba = b; a10 = ap;
    @(posedge clk); #2;
    cs_n = 1; {ras_n, cas_n, we_n} = OP_NOP; a10 = 0;
  endtask

  task automatic nop(); issue(OP_NOP, 0, 0); endtask

  task automatic st(input string tag, input int b, input int exp);
    check({tag, " state"}, int'(bank_state[3*b +: 3]), exp);
  endtask

  task automatic viol(input string tag, input int b, input logic [2:0] code);
    check({tag, " valid"}, int'(viol_valid), 1);
    check({tag, " bank"}, int'(viol_bank), b);
    check({tag, " code"}, int'(viol_cmd), int'(code));
  endtask

  task automatic quiet(input string tag);
    check({tag, " no-viol"}, int'(viol_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 0; cke = 1; cs_n = 1;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic open_bank(input logic b);
    issue(OP_ACT, b, 0); nop(); nop();
  endtask

  task automatic t_reset();
    do_reset();
    st("R1 b0", 0, 0); st("R1 b1", 1, 0); quiet("R1");
  endtask

  task automatic t_idle();
    do_reset();
    issue(OP_RD, 0, 0); viol("R2 read idle", 0, OP_RD); st("R2 b0", 0, 0);
    nop(); quiet("R9 pulse end");
    issue(OP_BST, 1, 0); viol("R2 bst idle", 1, OP_BST);
    issue(OP_REF, 0, 0); quiet("R2 ref");
    issue(OP_LMR, 0, 0); quiet("R2 lmr");
    issue(OP_PRE, 0, 0); quiet("R2 pre"); st("R2 pre idle", 0, 0);
  endtask

  task automatic t_activate();
    do_reset();
    issue(OP_ACT, 0, 0); quiet("R3 act"); st("R3 opening", 0, 1);
    issue(OP_ACT, 1, 0); quiet("R3 other bank"); st("R3 b1 opening", 1, 1);
    issue(OP_RD, 0, 0); viol("R3 early read", 0, OP_RD); st("R3 b0 open", 0, 2);
    st("R3 b1 still opening", 1, 1);
    issue(OP_RD, 0, 0); quiet("R3 read at tRCD"); st("R3 reading", 0, 3);
    st("R3 b1 open", 1, 2);
  endtask

  task automatic t_burst();
    do_reset();
    open_bank(1);
    issue(OP_RD, 1, 0); quiet("R4 read"); st("R4 reading", 1, 3);
    nop(); nop(); st("R4 burst last", 1, 3);
    nop(); st("R4 burst end", 1, 2);
    issue(OP_ACT, 1, 0); viol("R4 act open", 1, OP_ACT);
    issue(OP_WR, 1, 0); st("R4 writing", 1, 4);
    issue(OP_REF, 0, 0); viol("R4 ref busy", 1, OP_REF);
  endtask

  task automatic t_trunc();
    do_reset();
    open_bank(0);
    issue(OP_RD, 0, 0); nop();
    issue(OP_RD, 0, 0); quiet("R5 reread"); nop(); nop();
    st("R5 restarted", 0, 3);
    issue(OP_WR, 0, 0); st("R5 write in read", 0, 4);
    issue(OP_BST, 0, 0); quiet("R5 bst"); st("R5 bst open", 0, 2);
    issue(OP_WR, 0, 0);
    issue(OP_PRE, 0, 0); quiet("R5 pre trunc"); st("R6 closing", 0, 7);
    issue(OP_ACT, 0, 0); viol("R6 act closing", 0, OP_ACT); st("R6 still closing", 0, 7);
    nop(); st("R6 idle at tRP", 0, 0);
    issue(OP_ACT, 0, 0); quiet("R6 act after"); st("R6 reopen", 0, 1);
  endtask

  task automatic t_ap();
    do_reset();
    open_bank(0);
    issue(OP_RD, 0, 1); quiet("R7 rd ap"); st("R7 rd ap", 0, 5);
    issue(OP_PRE, 0, 0); viol("R7 pre in ap", 0, OP_PRE);
    issue(OP_ACT, 1, 0); quiet("R7 other bank"); st("R7 b1", 1, 1);
    nop(); nop(); nop(); st("R7 last ap cycle", 0, 5);
    nop(); st("R7 idle", 0, 0);
    open_bank(0);
    issue(OP_WR, 0, 1); st("R7 wr ap", 0, 6);
    for (int i = 0; i < BL + TRP - 2; i++) nop();
    st("R7 wr ap last", 0, 6);
    nop(); st("R7 wr ap idle", 0, 0);
  endtask

  task automatic t_allbank();
    do_reset();
    issue(OP_ACT, 1, 0);
    issue(OP_REF, 0, 0); viol("R8 ref busy", 1, OP_REF);
    nop(); st("R8 b1 open", 1, 2);
    issue(OP_PRE, 0, 1); quiet("R8 pre all");
    st("R8 b0 stays idle", 0, 0); st("R8 b1 closing", 1, 7);
    issue(OP_LMR, 1, 0); viol("R8 lmr closing", 1, OP_LMR);
    do_reset();
    issue(OP_ACT, 0, 0); issue(OP_ACT, 1, 0);
    issue(OP_REF, 1, 0); viol("R8 lowest bank", 0, OP_REF);
  endtask

  task automatic t_nop();
    do_reset();
    issue(OP_ACT, 0, 0);
    issue(OP_PRE, 0, 0, 1); quiet("R10 inhibit"); st("R10 inhibit", 0, 1);
    nop(); quiet("R10 nop"); st("R10 timer ran", 0, 2);
  endtask

  task automatic t_cke();
    do_reset();
    cke = 0;
    issue(OP_ACT, 0, 0); quiet("R11 act cke low"); st("R11 act ignored", 0, 0);
    issue(OP_RD, 0, 0); quiet("R11 rd cke low");
    cke = 1;
    issue(OP_RD, 0, 0); quiet("R11 rise edge");
    for (int i = 0; i < TXSR - 2; i++) nop();
    issue(OP_RD, 0, 0); quiet("R11 last xsr cycle");
    issue(OP_RD, 0, 0); viol("R11 checked again", 0, OP_RD);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_activate();
    t_burst();
    t_trunc();
    t_ap();
    t_allbank();
    t_nop();
    t_cke();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule